// File: doc/BRIEF.md
# Sequential Read Prefetch Engine

This block sits between a requester on the bus clock and a flash read port on a separate device clock. When prefetch is enabled, a bus read starts a stream. The device side fetches 32-bit words at consecutive word addresses and pushes them into a dual-clock FIFO, running ahead of the requester. Later bus reads that continue the stream are served straight from the FIFO, so mostly sequential traffic sees much higher read bandwidth.

A bus read that does not continue the stream is a miss. It flushes the buffered words and restarts fetching at the new address. Fetching pauses while the FIFO is full and resumes as the requester drains it. It never fetches across a 1 KB-aligned address: the stream stops there until a new bus request arrives. With prefetch disabled, every bus read costs exactly one device read.

The bus side allows one read in flight: the requester pulses `bus_req` with `bus_addr` and waits for the one-cycle `bus_rvalid` before it issues another. The device side also keeps one read outstanding: `dev_req` is a one-cycle pulse, and the matching word returns later with a one-cycle `dev_rvalid`.

Top module: `pf_seq_prefetch`

## Requirements
- R1: Every bus read returns, on `bus_rdata` with `bus_rvalid`, the device word stored at the requested byte address, in both modes.
- R2: With `pf_enable` low when a request is taken, that request causes exactly one device read, at the requested address, and no other device read follows it.
- R3: With `pf_enable` high, a request whose address is not the expected next address of the current stream is a miss. Fetching restarts at that address, and no word fetched before the miss is ever returned for it.
- R4: With `pf_enable` high, a request at the expected next address (previous request + 4), while a stream is live and that address is not 1 KB aligned, is a hit. It is served from the FIFO without restarting the stream.
- R5: At most one device read is outstanding: `dev_req` is not pulsed again until `dev_rvalid` has returned the previous word.
- R6: Fetching stops while the FIFO holds DEPTH (32) words. After one stream-starting request and no further reads, exactly DEPTH+1 device reads are made.
- R7: Fetching resumes as space frees. Each further hit allows exactly one more device read while the stream is away from a boundary.
- R8: Within a stream, device addresses increase by 4. An address whose low 10 bits are zero is only ever fetched as the start address of a request, so a stream begun at S makes at most (1024 - S mod 1024)/4 reads.
- R9: A request at a 1 KB-aligned address is always a miss and starts a new stream there, even when it is exactly the previous request + 4.
- R10: After reset `bus_rvalid` and `dev_req` stay low until a bus request arrives.
- R11: The FIFO never holds more than DEPTH words as seen from the device side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side active-low reset |
| pf_enable | input | 1 | 1 = prefetch on, 0 = one device read per request |
| bus_req | input | 1 | One-cycle read request pulse |
| bus_addr | input | 32 | Byte address of the request, word aligned |
| bus_rvalid | output | 1 | One-cycle pulse with returned data |
| bus_rdata | output | 32 | Returned read word |
| dev_clk | input | 1 | Device-side clock |
| dev_rst_n | input | 1 | Device-side active-low reset |
| dev_req | output | 1 | One-cycle device read pulse |
| dev_addr | output | 32 | Byte address of the device read |
| dev_rvalid | input | 1 | One-cycle pulse with device data |
| dev_rdata | input | 32 | Device read word |

## Verification
The bench drives short runs of requests separated by long idle gaps, so the number of device reads each request causes can be counted exactly. Those counts tell a hit (no new reads beyond one refill) from a miss (a fresh refill) and from disabled mode (exactly one read). Streams that start a few words below a 1 KB boundary separate the boundary stop from the FIFO-full stop. Back-to-back sequential runs, some of them crossing a boundary, show that the data order survives pausing, resuming and restarting. A jump to an unrelated address, and enable being turned off mid-stream, show that stale buffered words are never returned.

// File: rtl/pf_pkg.sv
package pf_pkg;

  typedef enum logic [1:0] {
    B_IDLE,
    B_WAIT_ACK,
    B_DISCARD,
    B_WAIT_DATA
  } bus_st_e;

  typedef enum logic {
    F_IDLE,
    F_RUN
  } dev_st_e;

  localparam int unsigned WORD_BYTES = 4;

  // binary to reflected Gray code
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray code back to binary
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // address of the following word
  function automatic logic [31:0] step_word(input logic [31:0] a);
    return a + 32'(WORD_BYTES);
  endfunction

  // true when the low lsb bits of the address are all zero
  function automatic logic on_boundary(input logic [31:0] a, input int unsigned lsb);
    logic [31:0] mask;
    mask = (32'd1 << lsb) - 32'd1;
    return (a & mask) == 32'd0;
  endfunction

endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/pf_ram.sv
module pf_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pf_dev_ctrl.sv
module pf_dev_ctrl
  import pf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 32,
  parameter int BOUND_BYTES = 1024,
  localparam int AW         = $clog2(DEPTH),
  localparam int PW         = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  // command from the bus domain (toggle synchronized, fields held stable)
  input  logic              cmd_tgl_s,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_single,
  input  logic [PW-1:0]     rd_gray_s,
  // device read port
  output logic              dev_req,
  output logic [ADDR_W-1:0] dev_addr,
  input  logic              dev_rvalid,
  input  logic [DATA_W-1:0] dev_rdata,
  // FIFO write side
  output logic              ram_we,
  output logic [AW-1:0]     ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [PW-1:0]     wr_gray,
  // flush handshake back to the bus domain
  output logic [PW-1:0]     flush_ptr,
  output logic              ack_tgl,
  // observation
  output logic [PW-1:0]     occ,
  output logic [ADDR_W-1:0] start_addr,
  output logic              restart_ev,
  output logic              issue_ev
);

  localparam int BLSB = $clog2(BOUND_BYTES);

  dev_st_e           st;
  logic              cmd_seen;
  logic              pending;
  logic              issue_done;
  logic              single;
  logic [PW-1:0]     wr_ptr;
  logic [ADDR_W-1:0] fetch_addr;
  logic [ADDR_W-1:0] fetch_next;
  logic [PW-1:0]     rd_bin_s;
  logic              room;
  logic              cmd_new;
  logic              accept;

  assign rd_bin_s   = PW'(from_gray(32'(rd_gray_s)));
  assign occ        = wr_ptr - rd_bin_s;
  assign room       = occ < PW'(DEPTH);
  assign cmd_new    = cmd_tgl_s != cmd_seen;
  assign fetch_next = ADDR_W'(step_word(32'(fetch_addr)));

  // a new command waits for any outstanding word, which is then dropped
  assign restart_ev = cmd_new && (!pending || dev_rvalid);
  assign issue_ev   = (st == F_RUN) && !pending && !cmd_new && !issue_done && room;
  assign accept     = (st == F_RUN) && pending && dev_rvalid && !cmd_new;

  assign ram_we    = accept;
  assign ram_waddr = wr_ptr[AW-1:0];
  assign ram_wdata = dev_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= F_IDLE;
      cmd_seen   <= 1'b0;
      ack_tgl    <= 1'b0;
      pending    <= 1'b0;
      issue_done <= 1'b0;
      single     <= 1'b0;
      wr_ptr     <= '0;
      wr_gray    <= '0;
      flush_ptr  <= '0;
      fetch_addr <= '0;
      start_addr <= '0;
      dev_req    <= 1'b0;
      dev_addr   <= '0;
    end else begin
      dev_req <= 1'b0;
      if (restart_ev) begin
        cmd_seen   <= cmd_tgl_s;
        ack_tgl    <= ~ack_tgl;
        flush_ptr  <= wr_ptr;
        fetch_addr <= cmd_addr;
        start_addr <= cmd_addr;
        single     <= cmd_single;
        issue_done <= 1'b0;
        pending    <= 1'b0;
        st         <= F_RUN;
      end else if (issue_ev) begin
        dev_req    <= 1'b1;
        dev_addr   <= fetch_addr;
        pending    <= 1'b1;
        fetch_addr <= fetch_next;
        issue_done <= single || on_boundary(32'(fetch_next), BLSB);
      end else if (accept) begin
        pending <= 1'b0;
        wr_ptr  <= wr_ptr + PW'(1);
        wr_gray <= PW'(to_gray(32'(wr_ptr + PW'(1))));
        if (issue_done) st <= F_IDLE;
      end
    end
  end

endmodule

// File: rtl/pf_bus_ctrl.sv
module pf_bus_ctrl
  import pf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 32,
  parameter int BOUND_BYTES = 1024,
  localparam int AW         = $clog2(DEPTH),
  localparam int PW         = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_enable,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  // command to the device domain
  output logic              cmd_tgl,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_single,
  // flush handshake from the device domain
  input  logic              ack_tgl_s,
  input  logic [PW-1:0]     flush_ptr,
  // FIFO read side
  input  logic [PW-1:0]     wr_gray_s,
  output logic [AW-1:0]     ram_raddr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [PW-1:0]     rd_gray,
  // observation
  output logic              hit_ev,
  output logic              miss_ev
);

  localparam int BLSB = $clog2(BOUND_BYTES);

  bus_st_e           st;
  logic              ack_seen;
  logic              stream_ok;
  logic [ADDR_W-1:0] exp_addr;
  logic [PW-1:0]     rd_ptr;
  logic [PW-1:0]     target;
  logic [PW-1:0]     wr_bin_s;
  logic              fifo_empty;
  logic              is_hit;
  logic              pop;
  logic              drop;

  assign wr_bin_s   = PW'(from_gray(32'(wr_gray_s)));
  assign fifo_empty = rd_ptr == wr_bin_s;
  assign ram_raddr  = rd_ptr[AW-1:0];

  assign is_hit  = pf_enable && stream_ok && (bus_addr == exp_addr) &&
                   !on_boundary(32'(exp_addr), BLSB);
  assign hit_ev  = (st == B_IDLE) && bus_req && is_hit;
  assign miss_ev = (st == B_IDLE) && bus_req && !is_hit;

  // discard one stale word per cycle so the Gray pointer moves by one bit
  assign drop = (st == B_DISCARD) && (rd_ptr != target);
  assign pop  = (st == B_WAIT_DATA) && !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= B_IDLE;
      ack_seen   <= 1'b0;
      stream_ok  <= 1'b0;
      exp_addr   <= '0;
      rd_ptr     <= '0;
      rd_gray    <= '0;
      target     <= '0;
      cmd_tgl    <= 1'b0;
      cmd_addr   <= '0;
      cmd_single <= 1'b0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= 1'b0;
      if (drop || pop) begin
        rd_ptr  <= rd_ptr + PW'(1);
        rd_gray <= PW'(to_gray(32'(rd_ptr + PW'(1))));
      end
      unique case (st)
        B_IDLE: begin
          if (bus_req) begin
            exp_addr <= ADDR_W'(step_word(32'(bus_addr)));
            if (is_hit) begin
              st <= B_WAIT_DATA;
            end else begin
              cmd_tgl    <= ~cmd_tgl;
              cmd_addr   <= bus_addr;
              cmd_single <= !pf_enable;
              stream_ok  <= pf_enable;
              st         <= B_WAIT_ACK;
            end
          end
        end
        B_WAIT_ACK: begin
          if (ack_tgl_s != ack_seen) begin
            ack_seen <= ack_tgl_s;
            target   <= flush_ptr;
            st       <= B_DISCARD;
          end
        end
        B_DISCARD: begin
          if (!drop) st <= B_WAIT_DATA;
        end
        B_WAIT_DATA: begin
          if (pop) begin
            bus_rvalid <= 1'b1;
            bus_rdata  <= ram_rdata;
            st         <= B_IDLE;
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pf_seq_prefetch.sv
module pf_seq_prefetch #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 32,
  parameter int BOUND_BYTES = 1024
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              pf_enable,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dev_clk,
  input  logic              dev_rst_n,
  output logic              dev_req,
  output logic [ADDR_W-1:0] dev_addr,
  input  logic              dev_rvalid,
  input  logic [DATA_W-1:0] dev_rdata
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic              cmd_tgl, cmd_tgl_s, cmd_single;
  logic [ADDR_W-1:0] cmd_addr;
  logic              ack_tgl, ack_tgl_s;
  logic [PW-1:0]     flush_ptr;
  logic [PW-1:0]     wr_gray, wr_gray_s;
  logic [PW-1:0]     rd_gray, rd_gray_s;
  logic              ram_we;
  logic [AW-1:0]     ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  // named internal events for the checker
  logic [PW-1:0]     dev_occ;
  logic [ADDR_W-1:0] dev_start_addr;
  logic              dev_restart, dev_issue;
  logic              bus_hit, bus_miss;

  pf_bus_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .BOUND_BYTES(BOUND_BYTES)
  ) u_bus (
    .clk(bus_clk), .rst_n(bus_rst_n), .pf_enable(pf_enable),
    .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .cmd_tgl(cmd_tgl), .cmd_addr(cmd_addr), .cmd_single(cmd_single),
    .ack_tgl_s(ack_tgl_s), .flush_ptr(flush_ptr),
    .wr_gray_s(wr_gray_s), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .rd_gray(rd_gray), .hit_ev(bus_hit), .miss_ev(bus_miss)
  );

  pf_dev_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .BOUND_BYTES(BOUND_BYTES)
  ) u_dev (
    .clk(dev_clk), .rst_n(dev_rst_n),
    .cmd_tgl_s(cmd_tgl_s), .cmd_addr(cmd_addr), .cmd_single(cmd_single),
    .rd_gray_s(rd_gray_s),
    .dev_req(dev_req), .dev_addr(dev_addr),
    .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .wr_gray(wr_gray), .flush_ptr(flush_ptr), .ack_tgl(ack_tgl),
    .occ(dev_occ), .start_addr(dev_start_addr),
    .restart_ev(dev_restart), .issue_ev(dev_issue)
  );

  pf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .wclk(dev_clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  pf_sync #(.W(1))  u_sync_cmd (.clk(dev_clk), .rst_n(dev_rst_n), .d(cmd_tgl), .q(cmd_tgl_s));
  pf_sync #(.W(PW)) u_sync_rd  (.clk(dev_clk), .rst_n(dev_rst_n), .d(rd_gray), .q(rd_gray_s));
  pf_sync #(.W(1))  u_sync_ack (.clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_tgl_s));
  pf_sync #(.W(PW)) u_sync_wr  (.clk(bus_clk), .rst_n(bus_rst_n), .d(wr_gray), .q(wr_gray_s));

endmodule

// File: rtl/pf_seq_prefetch_chk.sv
module pf_seq_prefetch_chk #(
  parameter int ADDR_W      = 32,
  parameter int DEPTH       = 32,
  parameter int BOUND_BYTES = 1024,
  parameter int PW          = 6
) (
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              bus_req,
  input logic              bus_rvalid,
  input logic              dev_clk,
  input logic              dev_rst_n,
  input logic              dev_req,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              dev_rvalid,
  input logic [PW-1:0]     dev_occ,
  input logic [ADDR_W-1:0] dev_start_addr
);

  localparam int BLSB = $clog2(BOUND_BYTES);

  logic              outst;
  logic [ADDR_W-1:0] last_addr;
  logic              bus_pend;

  always_ff @(posedge dev_clk or negedge dev_rst_n) begin
    if (!dev_rst_n) begin
      outst     <= 1'b0;
      last_addr <= '0;
    end else begin
      if (dev_req) begin
        outst     <= 1'b1;
        last_addr <= dev_addr;
      end else if (dev_rvalid) begin
        outst <= 1'b0;
      end
    end
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) bus_pend <= 1'b0;
    else if (bus_req) bus_pend <= 1'b1;
    else if (bus_rvalid) bus_pend <= 1'b0;
  end

  // R5
  one_outstanding_chk: assert property (@(posedge dev_clk) disable iff (!dev_rst_n)
    dev_req |-> !outst);

  // R8
  boundary_stop_chk: assert property (@(posedge dev_clk) disable iff (!dev_rst_n)
    (dev_req && dev_addr[BLSB-1:0] == '0) |-> dev_addr == dev_start_addr);

  // R8
  sequential_addr_chk: assert property (@(posedge dev_clk) disable iff (!dev_rst_n)
    (dev_req && dev_addr != dev_start_addr) |-> dev_addr == last_addr + ADDR_W'(4));

  // R11
  no_overflow_chk: assert property (@(posedge dev_clk) disable iff (!dev_rst_n)
    dev_occ <= PW'(DEPTH));

  // R10
  rvalid_pending_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    bus_rvalid |-> bus_pend);

endmodule

bind pf_seq_prefetch pf_seq_prefetch_chk #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .BOUND_BYTES(BOUND_BYTES), .PW(PW)
) u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_req(bus_req), .bus_rvalid(bus_rvalid),
  .dev_clk(dev_clk), .dev_rst_n(dev_rst_n), .dev_req(dev_req), .dev_addr(dev_addr),
  .dev_rvalid(dev_rvalid), .dev_occ(dev_occ), .dev_start_addr(dev_start_addr)
);

// File: tb/pf_seq_prefetch_test.sv
module pf_seq_prefetch_test;

  localparam int BUS_PERIOD = 10;
  localparam int DEV_PERIOD = 14;
  localparam int DEPTH      = 32;
  localparam int SETTLE     = 400;

  logic        bus_clk = 0, dev_clk = 0;
  logic        bus_rst_n = 0, dev_rst_n = 0;
  logic        pf_enable = 0;
  logic        bus_req = 0;
  logic [31:0] bus_addr = 0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        dev_req;
  logic [31:0] dev_addr;
  logic        dev_rvalid = 0;
  logic [31:0] dev_rdata = 0;

  int tests = 0, fails = 0;
  int dev_reads = 0;
  int bus_cycles = 0;
  bit in_read = 0;
  bit done = 0;

  // bench reference state for the stream
  bit          m_stream = 0;
  logic [31:0] m_exp = 0;
  logic [31:0] m_last_start = 0;
  logic [31:0] m_last_dev = 0;

  pf_seq_prefetch uut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .pf_enable(pf_enable),
    .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .dev_clk(dev_clk), .dev_rst_n(dev_rst_n),
    .dev_req(dev_req), .dev_addr(dev_addr),
    .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata)
  );

  always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
  always #(DEV_PERIOD/2) dev_clk = ~dev_clk;

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] ^ 16'hC3E1} + (a >> 2);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // device model: variable latency, one word per request
  int          lat_rot = 0;
  int          resp_cnt = 0;
  bit          resp_busy = 0;
  logic [31:0] resp_addr = 0;
  always @(negedge dev_clk) begin
    dev_rvalid = 0;
    if (resp_busy) begin
      if (resp_cnt == 0) begin
        dev_rvalid = 1;
        dev_rdata  = word_of(resp_addr);
        resp_busy  = 0;
      end else resp_cnt--;
    end
    if (dev_req) begin
      // R8: sequential, never across a 1 KB boundary unless it is a start address
      check(dev_addr == m_last_start ||
            (dev_addr == m_last_dev + 4 && dev_addr[9:0] != 10'd0),
            "R8 device address", dev_addr, m_last_dev + 4);
      m_last_dev = dev_addr;
      dev_reads++;
      resp_busy = 1;
      resp_addr = dev_addr;
      resp_cnt  = lat_rot;
      lat_rot   = (lat_rot + 1) % 3;
    end
  end

  // per-clock bus comparison: no data pulse outside a read
  always @(negedge bus_clk) begin
    bus_cycles++;
    if (!in_read && bus_rst_n) begin
      if (bus_rvalid) check(0, "R10 spurious rvalid", 32'(bus_rvalid), 0);
    end
    if (bus_cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic bus_read(input logic [31:0] a);
    int t;
    bit hit;
    hit = pf_enable && m_stream && a == m_exp && a[9:0] != 10'd0;
    if (!hit) begin
      m_last_start = a;
      m_stream = pf_enable;
    end
    m_exp = a + 4;
    @(negedge bus_clk);
    in_read  = 1;
    bus_req  = 1;
    bus_addr = a;
    @(negedge bus_clk);
    bus_req = 0;
    t = 0;
    while (!bus_rvalid && t < 3000) begin
      @(negedge bus_clk);
      t++;
    end
    // R1 R3 R4: the word must be the device word of the requested address
    check(bus_rvalid == 1'b1, "R1 response arrives", 32'(bus_rvalid), 1);
    check(bus_rdata == word_of(a), hit ? "R4 hit data" : "R3 miss data",
          bus_rdata, word_of(a));
    @(negedge bus_clk);
    in_read = 0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge dev_clk);
  endtask

  task automatic expect_reads(input int base, input int n, input string req);
    check(dev_reads - base == n, req, 32'(dev_reads - base), 32'(n));
  endtask

  initial begin
    int base;
    repeat (5) @(negedge bus_clk);
    bus_rst_n = 1;
    dev_rst_n = 1;
    repeat (20) @(negedge bus_clk);
    // R10
    check(bus_rvalid == 0, "R10 reset rvalid", 32'(bus_rvalid), 0);
    check(dev_reads == 0, "R10 no device read after reset", 32'(dev_reads), 0);

    // R2: disabled, one device read per request
    pf_enable = 0;
    base = dev_reads; bus_read(32'h100); settle(); expect_reads(base, 1, "R2 single read");
    base = dev_reads; bus_read(32'h104); settle(); expect_reads(base, 1, "R2 sequential still single");
    base = dev_reads; bus_read(32'h200); settle(); expect_reads(base, 1, "R2 jump single");

    // R6: one request fills DEPTH words ahead
    pf_enable = 1;
    base = dev_reads; bus_read(32'h2000); settle();
    expect_reads(base, DEPTH + 1, "R6 stall on full");
    // R7 / R4: each hit frees one slot
    base = dev_reads; bus_read(32'h2004); settle();
    expect_reads(base, 1, "R7 resume one word");
    base = dev_reads;
    for (int i = 2; i < 10; i++) bus_read(32'h2000 + 32'(i * 4));
    settle();
    expect_reads(base, 8, "R7 resume per hit");

    // R3: miss flushes and restarts
    base = dev_reads; bus_read(32'h3000); settle();
    expect_reads(base, DEPTH + 1, "R3 restart refill");

    // R8: stream ends at the 1 KB boundary
    base = dev_reads; bus_read(32'h43F0); settle();
    expect_reads(base, 4, "R8 boundary stop");
    base = dev_reads;
    bus_read(32'h43F4); bus_read(32'h43F8); bus_read(32'h43FC); settle();
    expect_reads(base, 0, "R8 hits below boundary");
    // R9: aligned address is a miss even when sequential
    base = dev_reads; bus_read(32'h4400); settle();
    expect_reads(base, DEPTH + 1, "R9 aligned restart");

    // R2: turning enable off mid-stream
    pf_enable = 0;
    base = dev_reads; bus_read(32'h4404); settle();
    expect_reads(base, 1, "R2 disable mid-stream");

    // R1: back-to-back sequential run, pauses and resumes
    pf_enable = 1;
    for (int i = 0; i < 64; i++) bus_read(32'h5000 + 32'(i * 4));
    // R1 R9: back-to-back run across a boundary
    for (int i = 0; i < 16; i++) bus_read(32'h63E0 + 32'(i * 4));
    // R3: irregular jumps
    bus_read(32'h7010); bus_read(32'h7014); bus_read(32'h7100); bus_read(32'h7010);
    settle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule